// File: doc/BRIEF.md
# Registered Memory-Module Command Front End

This block sits between a memory controller and the memory devices of a module. It takes the active-low chip selects, the three active-low command strobes (row, column, write), the clock enable, the row/column address, the bank address and the byte masks, and forwards them to the devices. A mode pin chooses how they travel. In registered mode the whole bundle is captured on one rising edge and presented on the next, which adds one cycle. In pass-through mode the bundle reaches the outputs combinationally in the same cycle.

The block also decodes the forwarded bundle into a command code with a strobe. For each command it gives the bank, the row or column, the auto-precharge and all-banks flags, and the chip selects that took part. The decode works on the forwarded signals, so it lines up with what the devices see in either mode. The memory array, the data path and any timing-parameter checks are outside the block.

Top module: `sdram_cmd_front`

## Requirements
- R1: With `reg_mode` high on two consecutive rising edges, the forwarded bundle (chip selects, command strobes, clock enable, bank, address, masks) equals the input bundle one cycle earlier.
- R2: With `reg_mode` low, every forwarded output equals its input in the same cycle.
- R3: While `rst_n` is low and `reg_mode` is high, the outputs hold the idle bundle: all chip selects high, the command strobes high, clock enable low, bank and address zero, all masks high. `cmd_valid` is low.
- R4: If every chip select is high, the code is INHIBIT (0). If a chip select is low and the row, column and write strobes are all high, the code is NOP (1). `cmd_valid` is low for both.
- R5: With a chip select low, the {row, column, write} strobe levels decode as follows: {L,H,H} is ACTIVATE (2), {H,L,H} is READ (3), {H,L,L} is WRITE (4), {H,H,L} is BURST_STOP (5), {L,H,L} is PRECHARGE (6) and {L,L,L} is MODE_LOAD (9).
- R6: The {L,L,H} pattern decodes to AUTO_REFRESH (7) when the forwarded clock enable is high and to SELF_REFRESH (8) when it is low.
- R7: On READ or WRITE, `cmd_auto_pre` equals address bit 10. It is low for every other code.
- R8: On PRECHARGE, `cmd_all_banks` equals address bit 10, and while it is set `cmd_bank` reads 0 whatever the bank input is. It is low for every other code.
- R9: `cmd_bank` carries the bank address on ACTIVATE, READ, WRITE and single-bank PRECHARGE. `cmd_row` carries the full address on ACTIVATE. `cmd_col` carries address bits 9..0 on READ and WRITE. Each of these fields is zero in every other case.
- R10: `cmd_valid` is high in exactly those cycles whose forwarded bundle holds a code other than INHIBIT or NOP. Back-to-back commands give one strobe cycle each, in the same cycle as the forwarded outputs.
- R11: On the first cycle after `reg_mode` rises, the outputs show the idle bundle of R3 and `cmd_valid` is low; no command from the pass-through period is replayed.
- R12: `cmd_sel` is the bitwise inverse of the forwarded chip selects when `cmd_valid` is high, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_mode | input | 1 | 1 = registered (one-cycle) path, 0 = same-cycle path |
| in_cs_n | input | 2 | Chip selects, active low |
| in_ras_n | input | 1 | Row strobe, active low |
| in_cas_n | input | 1 | Column strobe, active low |
| in_we_n | input | 1 | Write strobe, active low |
| in_cke | input | 1 | Clock enable |
| in_ba | input | 2 | Bank address |
| in_addr | input | 12 | Row/column address and opcode |
| in_mask | input | 8 | Byte masks |
| out_cs_n | output | 2 | Forwarded chip selects |
| out_ras_n | output | 1 | Forwarded row strobe |
| out_cas_n | output | 1 | Forwarded column strobe |
| out_we_n | output | 1 | Forwarded write strobe |
| out_cke | output | 1 | Forwarded clock enable |
| out_ba | output | 2 | Forwarded bank address |
| out_addr | output | 12 | Forwarded address |
| out_mask | output | 8 | Forwarded byte masks |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 4 | Decoded command code |
| cmd_sel | output | 2 | Chip selects that took part in the command |
| cmd_bank | output | 2 | Decoded bank |
| cmd_row | output | 12 | Decoded row |
| cmd_col | output | 10 | Decoded starting column |
| cmd_auto_pre | output | 1 | Auto precharge requested |
| cmd_all_banks | output | 1 | Precharge covers all banks |

## Verification
The hardest case to reach is a change of the mode pin. Right after the pin rises, the register must hold the idle bundle and not an old command captured during pass-through. To reach this, the random stimulus flips `reg_mode` on about one cycle in sixteen and keeps driving live commands across each flip. A directed sequence also switches into registered mode while an ACTIVATE sits on the inputs. The refresh split by clock-enable level and the A10 meaning that depends on the command are driven both directly and through random address and clock-enable values.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_INHIBIT    = 4'd0,
    CMD_NOP        = 4'd1,
    CMD_ACTIVATE   = 4'd2,
    CMD_READ       = 4'd3,
    CMD_WRITE      = 4'd4,
    CMD_BURST_STOP = 4'd5,
    CMD_PRECHARGE  = 4'd6,
    CMD_AUTO_REF   = 4'd7,
    CMD_SELF_REF   = 4'd8,
    CMD_MODE_LOAD  = 4'd9
  } cmd_e;

  // {row, column, write} strobe patterns, active low
  localparam logic [2:0] PAT_NOP   = 3'b111;
  localparam logic [2:0] PAT_ACT   = 3'b011;
  localparam logic [2:0] PAT_RD    = 3'b101;
  localparam logic [2:0] PAT_WR    = 3'b100;
  localparam logic [2:0] PAT_BST   = 3'b110;
  localparam logic [2:0] PAT_PRE   = 3'b010;
  localparam logic [2:0] PAT_REF   = 3'b001;
  localparam logic [2:0] PAT_MODE  = 3'b000;

endpackage

// File: rtl/cmd_capture_reg.sv
module cmd_capture_reg #(
  parameter int unsigned         WIDTH    = 28,
  parameter logic [WIDTH-1:0]    IDLE_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] q_next;

  // Load the live bundle in registered mode, park at idle otherwise
  always_comb begin
    if (cap_en) q_next = d_in;
    else        q_next = IDLE_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_out <= IDLE_VAL;
    else        q_out <= q_next;
  end

endmodule

// File: rtl/cmd_path_select.sv
module cmd_path_select #(
  parameter int unsigned WIDTH = 28
) (
  input  logic             use_reg,
  input  logic [WIDTH-1:0] live_bus,
  input  logic [WIDTH-1:0] held_bus,
  output logic [WIDTH-1:0] fwd_bus
);

  always_comb begin
    if (use_reg) fwd_bus = held_bus;
    else         fwd_bus = live_bus;
  end

endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned CS_W   = 2,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CS_W-1:0]   cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              valid,
  output cmd_e              code,
  output logic [CS_W-1:0]   sel,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] row,
  output logic [COL_W-1:0]  col,
  output logic              auto_pre,
  output logic              all_banks
);

  logic       any_sel;
  logic [2:0] pat;
  logic       a10;

  assign any_sel = ~&cs_n;
  assign pat     = {ras_n, cas_n, we_n};
  assign a10     = addr[AP_BIT];

  always_comb begin
    if (!any_sel) begin
      code = CMD_INHIBIT;
    end else begin
      unique case (pat)
        PAT_NOP:  code = CMD_NOP;
        PAT_ACT:  code = CMD_ACTIVATE;
        PAT_RD:   code = CMD_READ;
        PAT_WR:   code = CMD_WRITE;
        PAT_BST:  code = CMD_BURST_STOP;
        PAT_PRE:  code = CMD_PRECHARGE;
        PAT_REF:  code = cke ? CMD_AUTO_REF : CMD_SELF_REF;
        default:  code = CMD_MODE_LOAD;
      endcase
    end
  end

  always_comb begin
    valid     = (code != CMD_INHIBIT) && (code != CMD_NOP);
    sel       = valid ? ~cs_n : '0;
    bank      = '0;
    row       = '0;
    col       = '0;
    auto_pre  = 1'b0;
    all_banks = 1'b0;
    unique case (code)
      CMD_ACTIVATE: begin
        bank = ba;
        row  = addr;
      end
      CMD_READ, CMD_WRITE: begin
        bank     = ba;
        col      = addr[COL_W-1:0];
        auto_pre = a10;
      end
      CMD_PRECHARGE: begin
        all_banks = a10;
        bank      = a10 ? '0 : ba;
      end
      default: ;
    endcase
  end

  assert_inhibit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> (!valid && code == CMD_INHIBIT));

  assert_auto_pre_scope_R7: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> (code == CMD_READ || code == CMD_WRITE));

  assert_all_banks_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
    all_banks |-> (code == CMD_PRECHARGE && bank == '0));

  assert_sel_present_R12: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones(sel) >= 1));

  assert_refresh_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (any_sel && pat == PAT_REF) |-> (code == (cke ? CMD_AUTO_REF : CMD_SELF_REF)));

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned CS_W   = 2,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned MASK_W = 8,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_mode,
  input  logic [CS_W-1:0]   in_cs_n,
  input  logic              in_ras_n,
  input  logic              in_cas_n,
  input  logic              in_we_n,
  input  logic              in_cke,
  input  logic [BA_W-1:0]   in_ba,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [MASK_W-1:0] in_mask,
  output logic [CS_W-1:0]   out_cs_n,
  output logic              out_ras_n,
  output logic              out_cas_n,
  output logic              out_we_n,
  output logic              out_cke,
  output logic [BA_W-1:0]   out_ba,
  output logic [ADDR_W-1:0] out_addr,
  output logic [MASK_W-1:0] out_mask,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [CS_W-1:0]   cmd_sel,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0] cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_auto_pre,
  output logic              cmd_all_banks
);

  localparam int unsigned BUS_W = CS_W + 4 + BA_W + ADDR_W + MASK_W;
  localparam logic [BUS_W-1:0] IDLE_BUS =
    {{CS_W{1'b1}}, 3'b111, 1'b0, {BA_W{1'b0}}, {ADDR_W{1'b0}}, {MASK_W{1'b1}}};

  logic [BUS_W-1:0] live_bus;
  logic [BUS_W-1:0] held_bus;
  logic [BUS_W-1:0] fwd_bus;
  cmd_e             code_w;

  assign live_bus = {in_cs_n, in_ras_n, in_cas_n, in_we_n, in_cke, in_ba, in_addr, in_mask};

  cmd_capture_reg #(
    .WIDTH    (BUS_W),
    .IDLE_VAL (IDLE_BUS)
  ) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (reg_mode),
    .d_in   (live_bus),
    .q_out  (held_bus)
  );

  cmd_path_select #(
    .WIDTH (BUS_W)
  ) u_select (
    .use_reg  (reg_mode),
    .live_bus (live_bus),
    .held_bus (held_bus),
    .fwd_bus  (fwd_bus)
  );

  assign {out_cs_n, out_ras_n, out_cas_n, out_we_n, out_cke, out_ba, out_addr, out_mask} = fwd_bus;

  cmd_decode #(
    .CS_W   (CS_W),
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .COL_W  (COL_W),
    .AP_BIT (AP_BIT)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (out_cs_n),
    .ras_n     (out_ras_n),
    .cas_n     (out_cas_n),
    .we_n      (out_we_n),
    .cke       (out_cke),
    .ba        (out_ba),
    .addr      (out_addr),
    .valid     (cmd_valid),
    .code      (code_w),
    .sel       (cmd_sel),
    .bank      (cmd_bank),
    .row       (cmd_row),
    .col       (cmd_col),
    .auto_pre  (cmd_auto_pre),
    .all_banks (cmd_all_banks)
  );

  assign cmd_code = code_w;

  assert_one_cycle_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && $past(reg_mode) && $past(rst_n)) |-> (fwd_bus == $past(live_bus)));

  assert_same_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_mode |-> (out_addr == in_addr && out_cs_n == in_cs_n && out_cke == in_cke));

  assert_switch_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && !$past(reg_mode)) |-> (&out_cs_n && !cmd_valid && !out_cke));

endmodule

// File: tb/test_sdram_cmd_front.sv
`timescale 1ns/1ps
module test_sdram_cmd_front;

  localparam int CS_W   = 2;
  localparam int ADDR_W = 12;
  localparam int BA_W   = 2;
  localparam int MASK_W = 8;
  localparam int COL_W  = 10;
  localparam int BUS_W  = CS_W + 4 + BA_W + ADDR_W + MASK_W;
  localparam logic [BUS_W-1:0] IDLE =
    {{CS_W{1'b1}}, 3'b111, 1'b0, {BA_W{1'b0}}, {ADDR_W{1'b0}}, {MASK_W{1'b1}}};

  localparam logic [3:0] C_INH = 0, C_NOP = 1, C_ACT = 2, C_RD = 3, C_WR = 4,
                         C_BST = 5, C_PRE = 6, C_AREF = 7, C_SREF = 8, C_MODE = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_mode;
  logic [BUS_W-1:0] drv_bus;

  logic [CS_W-1:0]   in_cs_n;
  logic              in_ras_n, in_cas_n, in_we_n, in_cke;
  logic [BA_W-1:0]   in_ba;
  logic [ADDR_W-1:0] in_addr;
  logic [MASK_W-1:0] in_mask;
  logic [CS_W-1:0]   out_cs_n;
  logic              out_ras_n, out_cas_n, out_we_n, out_cke;
  logic [BA_W-1:0]   out_ba;
  logic [ADDR_W-1:0] out_addr;
  logic [MASK_W-1:0] out_mask;
  logic              cmd_valid;
  logic [3:0]        cmd_code;
  logic [CS_W-1:0]   cmd_sel;
  logic [BA_W-1:0]   cmd_bank;
  logic [ADDR_W-1:0] cmd_row;
  logic [COL_W-1:0]  cmd_col;
  logic              cmd_auto_pre, cmd_all_banks;

  assign {in_cs_n, in_ras_n, in_cas_n, in_we_n, in_cke, in_ba, in_addr, in_mask} = drv_bus;
  wire [BUS_W-1:0] out_bus = {out_cs_n, out_ras_n, out_cas_n, out_we_n, out_cke, out_ba, out_addr, out_mask};

  always #4 clk = ~clk;

  sdram_cmd_front i_sdram_cmd_front (
    .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode),
    .in_cs_n(in_cs_n), .in_ras_n(in_ras_n), .in_cas_n(in_cas_n), .in_we_n(in_we_n),
    .in_cke(in_cke), .in_ba(in_ba), .in_addr(in_addr), .in_mask(in_mask),
    .out_cs_n(out_cs_n), .out_ras_n(out_ras_n), .out_cas_n(out_cas_n), .out_we_n(out_we_n),
    .out_cke(out_cke), .out_ba(out_ba), .out_addr(out_addr), .out_mask(out_mask),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_sel(cmd_sel), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_auto_pre(cmd_auto_pre), .cmd_all_banks(cmd_all_banks)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [BUS_W-1:0] exp_reg = IDLE;
  logic [BUS_W-1:0] cur_bus = IDLE;
  logic             cur_mode = 1'b1;
  logic             last_mode = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] mk(input logic [1:0] cs, input logic [2:0] rcw,
      input logic cke, input logic [1:0] ba, input logic [11:0] a, input logic [7:0] m);
    return {cs, rcw, cke, ba, a, m};
  endfunction

  function automatic logic [3:0] ref_code(input logic [BUS_W-1:0] b);
    logic [CS_W-1:0] cs; logic [2:0] rcw; logic ke;
    cs  = b[BUS_W-1 -: CS_W];
    rcw = b[BUS_W-CS_W-1 -: 3];
    ke  = b[BUS_W-CS_W-4];
    if (cs == '1) return C_INH;
    case (rcw)
      3'b111: return C_NOP;
      3'b011: return C_ACT;
      3'b101: return C_RD;
      3'b100: return C_WR;
      3'b110: return C_BST;
      3'b010: return C_PRE;
      3'b001: return ke ? C_AREF : C_SREF;
      default: return C_MODE;
    endcase
  endfunction

  task automatic verify();
    logic [BUS_W-1:0] ef;
    logic [3:0] c;
    logic [ADDR_W-1:0] a;
    logic [BA_W-1:0] ba;
    logic [CS_W-1:0] cs;
    logic ev, eap, eab;
    logic [BA_W-1:0] eb;
    logic [ADDR_W-1:0] er;
    logic [COL_W-1:0] ec;
    string t, tc;
    ef = cur_mode ? exp_reg : cur_bus;
    t  = !cur_mode ? "R2" : (last_mode ? "R1" : "R11");
    check(out_bus == ef, t, "forwarded bundle", 32'(out_bus), 32'(ef));
    c  = ref_code(ef);
    cs = ef[BUS_W-1 -: CS_W];
    ba = ef[ADDR_W+MASK_W +: BA_W];
    a  = ef[MASK_W +: ADDR_W];
    tc = (c == C_INH || c == C_NOP) ? "R4" : ((c == C_AREF || c == C_SREF) ? "R6" : "R5");
    check(cmd_code == c, tc, "cmd_code", 32'(cmd_code), 32'(c));
    ev = (c != C_INH && c != C_NOP);
    check(cmd_valid == ev, "R10", "cmd_valid", 32'(cmd_valid), 32'(ev));
    check(cmd_sel == (ev ? ~cs : '0), "R12", "cmd_sel", 32'(cmd_sel), 32'(ev ? ~cs : '0));
    eap = (c == C_RD || c == C_WR) && a[10];
    eab = (c == C_PRE) && a[10];
    check(cmd_auto_pre == eap, "R7", "cmd_auto_pre", 32'(cmd_auto_pre), 32'(eap));
    check(cmd_all_banks == eab, "R8", "cmd_all_banks", 32'(cmd_all_banks), 32'(eab));
    eb = (c == C_ACT || c == C_RD || c == C_WR || (c == C_PRE && !a[10])) ? ba : '0;
    er = (c == C_ACT) ? a : '0;
    ec = (c == C_RD || c == C_WR) ? a[COL_W-1:0] : '0;
    check(cmd_bank == eb, (c == C_PRE) ? "R8" : "R9", "cmd_bank", 32'(cmd_bank), 32'(eb));
    check(cmd_row == er && cmd_col == ec, "R9", "cmd_row/cmd_col",
          {cmd_row, 10'(cmd_col)}, {er, 10'(ec)});
  endtask

  task automatic step(input logic m, input logic [BUS_W-1:0] b);
    @(negedge clk);
    exp_reg   = (rst_n && cur_mode) ? cur_bus : IDLE;
    last_mode = cur_mode;
    cur_mode  = m;
    cur_bus   = b;
    reg_mode  = m;
    drv_bus   = b;
    #1;
    verify();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_0c3d);
    rst_n    = 1'b0;
    reg_mode = 1'b1;
    drv_bus  = mk(2'b00, 3'b011, 1'b1, 2'd3, 12'hFFF, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3 reset state with a live command on the inputs
    check(out_bus == IDLE, "R3", "reset bundle", 32'(out_bus), 32'(IDLE));
    check(cmd_valid == 1'b0, "R3", "reset strobe", 32'(cmd_valid), 32'd0);
    rst_n    = 1'b1;
    cur_mode = 1'b1;
    cur_bus  = drv_bus;
    exp_reg  = IDLE;

    // directed, registered mode
    step(1, mk(2'b10, 3'b011, 1, 2'd2, 12'hABC, 8'h00)); // R9 activate
    step(1, mk(2'b10, 3'b101, 1, 2'd1, 12'h555, 8'h0F)); // R7 read with auto precharge
    step(1, mk(2'b01, 3'b100, 1, 2'd3, 12'h1AA, 8'hF0)); // R7 write, no auto precharge
    step(1, mk(2'b00, 3'b010, 1, 2'd3, 12'h400, 8'h00)); // R8 precharge all
    step(1, mk(2'b10, 3'b010, 1, 2'd1, 12'h000, 8'h00)); // R8 single bank
    step(1, mk(2'b10, 3'b001, 1, 2'd0, 12'h000, 8'h00)); // R6 auto refresh
    step(1, mk(2'b10, 3'b001, 0, 2'd0, 12'h000, 8'h00)); // R6 self refresh
    step(1, mk(2'b10, 3'b000, 1, 2'd0, 12'h032, 8'h00)); // R5 mode load
    step(1, mk(2'b10, 3'b110, 1, 2'd0, 12'h000, 8'h00)); // R5 burst stop
    step(1, mk(2'b10, 3'b111, 1, 2'd2, 12'h7FF, 8'h00)); // R4 nop
    step(1, mk(2'b11, 3'b011, 1, 2'd2, 12'h7FF, 8'h00)); // R4 inhibit masks activate
    step(1, mk(2'b11, 3'b011, 1, 2'd2, 12'h7FF, 8'h00));
    // pass-through mode, back-to-back
    step(0, mk(2'b10, 3'b011, 1, 2'd0, 12'h123, 8'h00)); // R2
    step(0, mk(2'b10, 3'b101, 1, 2'd0, 12'h7FF, 8'h00)); // R10 back to back
    step(0, mk(2'b10, 3'b010, 1, 2'd2, 12'h400, 8'h00));
    // R11 switch into registered mode with a live command
    step(1, mk(2'b01, 3'b011, 1, 2'd1, 12'h321, 8'h00));
    step(1, mk(2'b01, 3'b100, 1, 2'd1, 12'h404, 8'h00));
    step(1, mk(2'b11, 3'b111, 1, 2'd0, 12'h000, 8'hFF));

    // constrained random
    for (int i = 0; i < 2000; i++) begin
      logic m;
      logic [1:0] cs;
      logic [2:0] rcw;
      logic ke;
      m   = (($urandom % 16) == 0) ? ~cur_mode : cur_mode;
      cs  = (($urandom % 8) == 0) ? 2'b11 : 2'($urandom % 3);
      rcw = 3'($urandom);
      ke  = (($urandom % 4) != 0);
      step(m, mk(cs, rcw, ke, 2'($urandom), 12'($urandom), 8'($urandom)));
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule